// File: doc/BRIEF.md
# Feature-Gated Integer Execute Unit

This block is the execute stage of a small 32-bit RISC core. One instruction word is presented each cycle, together with the two source operands that the register file has already read. One clock edge later, the unit returns a registered result: a write-enable, a destination register index, a 32-bit result value and a 3-bit trap code.

The unit handles the following operations:

- addition and subtraction;
- the five bitwise logic operations;
- the two high-half immediate operations;
- six compare operations;
- three kinds of shift;
- byte and half-word sign extension;
- multiply;
- unsigned divide and remainder.

Four build-time switches decide whether the multiplier, the divider, the barrel shifter and the sign extender exist. When a unit is left out, its opcodes become illegal-instruction traps. There is one exception: a right shift by exactly one position still works without the barrel shifter. The unit also reports three more events through the trap code: a zero divisor, a halt request, and the opcodes that belong to other pipeline stages. Fetch, loads and stores, branches and control registers are outside the unit.

Top module: `feat_exec_unit`

## Requirements
- R1: Opcode is insn[31:26]. If insn[31] is 1, the instruction is register-register: the destination is insn[15:11] and the operands are opnd_a (field 25:21) and opnd_b (field 20:16). If insn[31] is 0, the instruction is register-immediate: the destination is insn[20:16] and the immediate is insn[15:0]. Each accepted instruction produces exactly one out_valid pulse one clock later, and idle cycles produce no output.
- R2: The arithmetic and logic opcodes are add (13 immediate, 45 register), sub (50), and (8/40), or (14/46), xor (6/38), nor (1/33) and xnor (9/41). Immediate add sign-extends the immediate. Immediate and, or, xor, nor and xnor zero-extend it.
- R3: Opcode 24 computes a AND (imm<<16), and opcode 30 computes a OR (imm<<16).
- R4: The compare opcodes are eq (25/57), gt signed (26/58), ge signed (27/59), ge unsigned (28/60), gt unsigned (29/61) and ne (31/63). A compare writes 1 when its condition holds and 0 otherwise. The immediate forms of eq, ne, gt and ge sign-extend the immediate; the unsigned forms zero-extend it.
- R5: The shift opcodes are left (15/47), arithmetic right (5/37) and logical right (0/32). The shift amount is opnd_b[4:0] in register form and insn[4:0] in immediate form.
- R6: Without the barrel shifter, every left shift traps as illegal. A right shift traps unless its amount is exactly 1, in which case it executes normally.
- R7: Multiply (2 with a sign-extended immediate, 34), divide/remainder (35/49) and sign-extend byte/half (44/55) trap as illegal when their option is disabled. Multiply returns the low 32 bits of the product.
- R8: Opcode 35 returns the unsigned quotient and opcode 49 the unsigned remainder. A zero divisor raises the divide-by-zero trap and suppresses the write.
- R9: Opcode 40 with insn[25:11] all zero raises the halt trap instead of writing.
- R10: The trap codes are 0 none, 1 illegal, 2 divide-by-zero and 3 halt. Any nonzero trap holds wb_en low.
- R11: A result aimed at register 0 never raises wb_en.
- R12: Every other opcode (one that belongs to another stage) gives out_valid with wb_en low and trap code 0.
- R13: While rst_n is low, out_valid and wb_en are 0 and trap_code is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| insn | input | 32 | Instruction word |
| opnd_a | input | 32 | Value of register field 25:21 |
| opnd_b | input | 32 | Value of register field 20:16 |
| out_valid | output | 1 | Registered result present |
| wb_en | output | 1 | Write the result back |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 32 | Result value |
| trap_code | output | 3 | 0 none, 1 illegal, 2 divide by zero, 3 halt |

## Verification
The assertions assume three things about the inputs:

- `in_valid` is never unknown after reset.
- `opnd_a` and `opnd_b` are the true register values of the instruction's fields.
- Halt and divide-by-zero detection relies only on the instruction word and `opnd_b` of the same cycle.

The stimulus stays within these assumptions because it drives every input from the bench at the falling edge and keeps the operands fully defined. It draws random opcodes over the whole 6-bit space. It biases the operands and shift fields toward 0, 1 and all-ones, so that zero divisors, shift-by-one cases and halt patterns come up often. Two copies of the unit run side by side: one with every option present and one with every option absent.

// File: rtl/feu_pkg.sv
package feu_pkg;
    localparam int XW  = 32;
    localparam int RW  = 5;
    localparam int OPW = 6;
    localparam int TW  = 3;
    localparam int IMW = 16;

    typedef enum logic [4:0] {
        U_NONE, U_ADD, U_SUB, U_AND, U_OR, U_XOR, U_NOR, U_XNOR,
        U_ANDHI, U_ORHI, U_CEQ, U_CNE, U_CGT, U_CGE, U_CGTU, U_CGEU,
        U_SHL, U_SHRA, U_SHRL, U_MUL, U_DIV, U_REM, U_SXB, U_SXH
    } uop_e;

    typedef enum logic [TW-1:0] {
        TRAP_NONE = 3'd0,
        TRAP_ILL  = 3'd1,
        TRAP_DIVZ = 3'd2,
        TRAP_HALT = 3'd3
    } trap_e;

    typedef enum logic [1:0] {IMM_SIGN, IMM_ZERO, IMM_HIGH} immk_e;

    typedef struct packed {
        uop_e            uop;
        logic            is_rr;
        logic [RW-1:0]   dst;
        immk_e           immk;
        logic            halt;
    } dec_t;

    typedef struct packed {
        logic            valid;
        logic            wen;
        logic [RW-1:0]   idx;
        logic [XW-1:0]   data;
        trap_e           trap;
    } res_t;
endpackage

// File: rtl/feu_decode.sv
module feu_decode
    import feu_pkg::*;
(
    input  logic [XW-1:0] insn,
    output dec_t          dec
);
    localparam int OP_LSB = XW - OPW;

    logic [OPW-1:0] opc;
    assign opc = insn[XW-1:OP_LSB];

    always_comb begin
        dec.is_rr = insn[XW-1];
        dec.dst   = insn[XW-1] ? insn[15:11] : insn[20:16];
        dec.halt  = (opc == 6'd40) && (insn[25:11] == '0);
        case (opc)
            6'd0,  6'd32: dec.uop = U_SHRL;
            6'd1,  6'd33: dec.uop = U_NOR;
            6'd2,  6'd34: dec.uop = U_MUL;
            6'd5,  6'd37: dec.uop = U_SHRA;
            6'd6,  6'd38: dec.uop = U_XOR;
            6'd8,  6'd40: dec.uop = U_AND;
            6'd9,  6'd41: dec.uop = U_XNOR;
            6'd13, 6'd45: dec.uop = U_ADD;
            6'd14, 6'd46: dec.uop = U_OR;
            6'd15, 6'd47: dec.uop = U_SHL;
            6'd24:        dec.uop = U_ANDHI;
            6'd25, 6'd57: dec.uop = U_CEQ;
            6'd26, 6'd58: dec.uop = U_CGT;
            6'd27, 6'd59: dec.uop = U_CGE;
            6'd28, 6'd60: dec.uop = U_CGEU;
            6'd29, 6'd61: dec.uop = U_CGTU;
            6'd30:        dec.uop = U_ORHI;
            6'd31, 6'd63: dec.uop = U_CNE;
            6'd35:        dec.uop = U_DIV;
            6'd44:        dec.uop = U_SXB;
            6'd49:        dec.uop = U_REM;
            6'd50:        dec.uop = U_SUB;
            6'd55:        dec.uop = U_SXH;
            default:      dec.uop = U_NONE;
        endcase
        case (dec.uop)
            U_AND, U_OR, U_XOR, U_NOR, U_XNOR, U_CGEU, U_CGTU: dec.immk = IMM_ZERO;
            U_ANDHI, U_ORHI:                                   dec.immk = IMM_HIGH;
            default:                                           dec.immk = IMM_SIGN;
        endcase
    end
endmodule

// File: rtl/feu_alu.sv
module feu_alu
    import feu_pkg::*;
(
    input  uop_e          uop,
    input  logic [XW-1:0] a,
    input  logic [XW-1:0] b,
    output logic [XW-1:0] y
);
    logic flag;

    always_comb begin
        flag = 1'b0;
        case (uop)
            U_CEQ:  flag = (a == b);
            U_CNE:  flag = (a != b);
            U_CGT:  flag = ($signed(a) >  $signed(b));
            U_CGE:  flag = ($signed(a) >= $signed(b));
            U_CGTU: flag = (a >  b);
            U_CGEU: flag = (a >= b);
            default: flag = 1'b0;
        endcase
    end

    always_comb begin
        case (uop)
            U_ADD:            y = a + b;
            U_SUB:            y = a - b;
            U_AND, U_ANDHI:   y = a & b;
            U_OR,  U_ORHI:    y = a | b;
            U_XOR:            y = a ^ b;
            U_NOR:            y = ~(a | b);
            U_XNOR:           y = ~(a ^ b);
            U_CEQ, U_CNE, U_CGT, U_CGE, U_CGTU, U_CGEU:
                              y = {{(XW-1){1'b0}}, flag};
            U_SXB:            y = {{(XW-8){a[7]}}, a[7:0]};
            U_SXH:            y = {{(XW-16){a[15]}}, a[15:0]};
            default:          y = '0;
        endcase
    end
endmodule

// File: rtl/feu_shift.sv
module feu_shift
    import feu_pkg::*;
#(
    parameter bit HAS_BARREL = 1'b1
)(
    input  uop_e                   uop,
    input  logic [XW-1:0]          a,
    input  logic [$clog2(XW)-1:0]  amt,
    output logic [XW-1:0]          y,
    output logic                   ok
);
    generate
        if (HAS_BARREL) begin : g_barrel
            always_comb begin
                ok = 1'b1;
                case (uop)
                    U_SHL:   y = a << amt;
                    U_SHRA:  y = $unsigned($signed(a) >>> amt);
                    U_SHRL:  y = a >> amt;
                    default: y = '0;
                endcase
            end
        end else begin : g_single
            // only a one-place right shift is wired
            always_comb begin
                ok = (uop != U_SHL) && (amt == 1);
                case (uop)
                    U_SHRA:  y = {a[XW-1], a[XW-1:1]};
                    U_SHRL:  y = {1'b0, a[XW-1:1]};
                    default: y = '0;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/feu_muldiv.sv
module feu_muldiv
    import feu_pkg::*;
#(
    parameter bit HAS_MUL = 1'b1,
    parameter bit HAS_DIV = 1'b1
)(
    input  uop_e          uop,
    input  logic [XW-1:0] a,
    input  logic [XW-1:0] b,
    output logic [XW-1:0] y,
    output logic          mul_ok,
    output logic          div_ok
);
    logic [XW-1:0] prod;
    logic [XW-1:0] quot;
    logic [XW-1:0] remd;

    generate
        if (HAS_MUL) begin : g_mul
            assign prod   = a * b;
            assign mul_ok = 1'b1;
        end else begin : g_nomul
            assign prod   = '0;
            assign mul_ok = 1'b0;
        end
        if (HAS_DIV) begin : g_div
            assign quot   = (b == '0) ? '0 : a / b;
            assign remd   = (b == '0) ? '0 : a % b;
            assign div_ok = 1'b1;
        end else begin : g_nodiv
            assign quot   = '0;
            assign remd   = '0;
            assign div_ok = 1'b0;
        end
    endgenerate

    always_comb begin
        case (uop)
            U_MUL:   y = prod;
            U_DIV:   y = quot;
            U_REM:   y = remd;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/feat_exec_unit.sv
module feat_exec_unit
    import feu_pkg::*;
#(
    parameter bit HAS_MUL   = 1'b1,
    parameter bit HAS_DIV   = 1'b1,
    parameter bit HAS_SHIFT = 1'b1,
    parameter bit HAS_SEXT  = 1'b1
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [31:0]   insn,
    input  logic [31:0]   opnd_a,
    input  logic [31:0]   opnd_b,
    output logic          out_valid,
    output logic          wb_en,
    output logic [4:0]    wb_idx,
    output logic [31:0]   wb_data,
    output logic [2:0]    trap_code
);
    localparam int SAW = $clog2(XW);

    dec_t             dec;
    logic [XW-1:0]    bop;
    logic [SAW-1:0]   amt;
    logic [XW-1:0]    alu_y;
    logic [XW-1:0]    sh_y;
    logic [XW-1:0]    md_y;
    logic             sh_ok;
    logic             mul_ok;
    logic             div_ok;
    logic             is_sh;
    logic             is_md;
    logic             illegal;
    logic             divz;
    logic [XW-1:0]    res_y;
    trap_e            trap;
    res_t             st_d;
    res_t             st_q;

    feu_decode u_dec (.insn(insn), .dec(dec));

    // operand b: register value or extended immediate
    always_comb begin
        if (dec.is_rr) begin
            bop = opnd_b;
        end else begin
            case (dec.immk)
                IMM_ZERO: bop = {{(XW-IMW){1'b0}}, insn[IMW-1:0]};
                IMM_HIGH: bop = {insn[IMW-1:0], {(XW-IMW){1'b0}}};
                default:  bop = {{(XW-IMW){insn[IMW-1]}}, insn[IMW-1:0]};
            endcase
        end
        amt = dec.is_rr ? opnd_b[SAW-1:0] : insn[SAW-1:0];
    end

    feu_alu u_alu (.uop(dec.uop), .a(opnd_a), .b(bop), .y(alu_y));

    feu_shift #(.HAS_BARREL(HAS_SHIFT)) u_sh (
        .uop(dec.uop), .a(opnd_a), .amt(amt), .y(sh_y), .ok(sh_ok)
    );

    feu_muldiv #(.HAS_MUL(HAS_MUL), .HAS_DIV(HAS_DIV)) u_md (
        .uop(dec.uop), .a(opnd_a), .b(bop), .y(md_y),
        .mul_ok(mul_ok), .div_ok(div_ok)
    );

    always_comb begin
        is_sh = (dec.uop == U_SHL) || (dec.uop == U_SHRA) || (dec.uop == U_SHRL);
        is_md = (dec.uop == U_MUL) || (dec.uop == U_DIV) || (dec.uop == U_REM);

        illegal = (is_sh && !sh_ok)
               || ((dec.uop == U_MUL) && !mul_ok)
               || (((dec.uop == U_DIV) || (dec.uop == U_REM)) && !div_ok)
               || (((dec.uop == U_SXB) || (dec.uop == U_SXH)) && !HAS_SEXT);
        divz = ((dec.uop == U_DIV) || (dec.uop == U_REM)) && div_ok && (bop == '0);

        if (dec.halt)        trap = TRAP_HALT;
        else if (illegal)    trap = TRAP_ILL;
        else if (divz)       trap = TRAP_DIVZ;
        else                 trap = TRAP_NONE;

        if (is_sh)           res_y = sh_y;
        else if (is_md)      res_y = md_y;
        else                 res_y = alu_y;

        st_d.valid = in_valid;
        st_d.trap  = in_valid ? trap : TRAP_NONE;
        st_d.wen   = in_valid && (trap == TRAP_NONE) && (dec.uop != U_NONE)
                     && (dec.dst != '0);
        st_d.idx   = in_valid ? dec.dst : '0;
        st_d.data  = st_d.wen ? res_y : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign wb_en     = st_q.wen;
    assign wb_idx    = st_q.idx;
    assign wb_data   = st_q.data;
    assign trap_code = st_q.trap;
endmodule

// File: rtl/feat_exec_unit_chk.sv
module feat_exec_unit_chk #(
    parameter bit HAS_MUL   = 1'b1,
    parameter bit HAS_DIV   = 1'b1,
    parameter bit HAS_SHIFT = 1'b1
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] insn,
    input  logic [31:0] opnd_b,
    input  logic        out_valid,
    input  logic        wb_en,
    input  logic [4:0]  wb_idx,
    input  logic [31:0] wb_data,
    input  logic [2:0]  trap_code
);
    logic [5:0] opc;
    logic       is_cmp;
    assign opc    = insn[31:26];
    assign is_cmp = (opc[4:0] >= 5'd25 && opc[4:0] <= 5'd29) || (opc[4:0] == 5'd31);

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                          // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wb_en && trap_code == 3'd0));      // R1
    AST_CMP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_cmp) |=> (wb_data[31:1] == 31'd0));              // R4
    AST_LEFT_SHIFT_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !HAS_SHIFT && (opc == 6'd15 || opc == 6'd47)) |=> (trap_code == 3'd1)); // R6
    AST_NOMUL_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !HAS_MUL && (opc == 6'd2 || opc == 6'd34)) |=> (trap_code == 3'd1)); // R7
    AST_DIVZERO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && HAS_DIV && (opc == 6'd35 || opc == 6'd49) && opnd_b == 32'd0)
        |=> (trap_code == 3'd2 && !wb_en));                               // R8
    AST_HALT_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[31:11] == {6'd40, 15'd0}) |=> (trap_code == 3'd3)); // R9
    AST_TRAP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_code != 3'd0) |-> !wb_en);                                  // R10
    AST_ZERO_REG_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_idx != 5'd0));                                      // R11
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !wb_en));                               // R13
endmodule

bind feat_exec_unit feat_exec_unit_chk #(
    .HAS_MUL(HAS_MUL), .HAS_DIV(HAS_DIV), .HAS_SHIFT(HAS_SHIFT)
) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .opnd_b(opnd_b),
    .out_valid(out_valid), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .trap_code(trap_code)
);

// File: tb/feat_exec_unit_tb_top.sv
module feat_exec_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        f_vld, f_wen, l_vld, l_wen;
    logic [4:0]  f_idx, l_idx;
    logic [31:0] f_dat, l_dat;
    logic [2:0]  f_trp, l_trp;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    feat_exec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(f_vld), .wb_en(f_wen),
        .wb_idx(f_idx), .wb_data(f_dat), .trap_code(f_trp)
    );

    feat_exec_unit #(.HAS_MUL(1'b0), .HAS_DIV(1'b0), .HAS_SHIFT(1'b0), .HAS_SEXT(1'b0)) dut_lite_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(l_vld), .wb_en(l_wen),
        .wb_idx(l_idx), .wb_data(l_dat), .trap_code(l_trp)
    );

    // {wen, idx[4:0], data[31:0], trap[2:0]}
    function automatic logic [40:0] model(input logic [31:0] ins, input logic [31:0] a,
                                          input logic [31:0] b, input bit full);
        logic [5:0]  op;
        logic [4:0]  d, sa;
        logic [31:0] se, ze, hi, y;
        bit known, ill, dz, hlt;
        logic [2:0] tr;
        op = ins[31:26];
        d  = ins[31] ? ins[15:11] : ins[20:16];
        se = {{16{ins[15]}}, ins[15:0]};
        ze = {16'h0, ins[15:0]};
        hi = {ins[15:0], 16'h0};
        sa = ins[31] ? b[4:0] : ins[4:0];
        known = 1; ill = 0; dz = 0; hlt = 0; y = '0;
        case (op)
            6'd0, 6'd32:  begin y = a >> sa; ill = !full && sa != 5'd1; end
            6'd5, 6'd37:  begin y = $unsigned($signed(a) >>> sa); ill = !full && sa != 5'd1; end
            6'd15, 6'd47: begin y = a << sa; ill = !full; end
            6'd1:  y = ~(a | ze);   6'd33: y = ~(a | b);
            6'd6:  y = a ^ ze;      6'd38: y = a ^ b;
            6'd8:  y = a & ze;
            6'd40: begin y = a & b; hlt = (ins[25:11] == 15'd0); end
            6'd9:  y = ~(a ^ ze);   6'd41: y = ~(a ^ b);
            6'd13: y = a + se;      6'd45: y = a + b;
            6'd14: y = a | ze;      6'd46: y = a | b;
            6'd50: y = a - b;
            6'd24: y = a & hi;      6'd30: y = a | hi;
            6'd25: y = {31'd0, a == se};  6'd57: y = {31'd0, a == b};
            6'd31: y = {31'd0, a != se};  6'd63: y = {31'd0, a != b};
            6'd26: y = {31'd0, $signed(a) >  $signed(se)};
            6'd58: y = {31'd0, $signed(a) >  $signed(b)};
            6'd27: y = {31'd0, $signed(a) >= $signed(se)};
            6'd59: y = {31'd0, $signed(a) >= $signed(b)};
            6'd28: y = {31'd0, a >= ze};  6'd60: y = {31'd0, a >= b};
            6'd29: y = {31'd0, a >  ze};  6'd61: y = {31'd0, a >  b};
            6'd2:  begin y = a * se; ill = !full; end
            6'd34: begin y = a * b;  ill = !full; end
            6'd35: begin ill = !full; dz = (b == 0); y = (b == 0) ? 0 : a / b; end
            6'd49: begin ill = !full; dz = (b == 0); y = (b == 0) ? 0 : a % b; end
            6'd44: begin y = {{24{a[7]}}, a[7:0]};   ill = !full; end
            6'd55: begin y = {{16{a[15]}}, a[15:0]}; ill = !full; end
            default: known = 0;
        endcase
        tr = hlt ? 3'd3 : ill ? 3'd1 : dz ? 3'd2 : 3'd0;
        return {known && tr == 3'd0 && d != 5'd0, d, y, tr};
    endfunction

    function automatic string req_of(input logic [31:0] ins);
        logic [5:0] op;
        op = ins[31:26];
        if (op == 6'd40 && ins[25:11] == 15'd0) return "R9";
        case (op)
            6'd0, 6'd32, 6'd5, 6'd37, 6'd15, 6'd47: return "R5/R6";
            6'd24, 6'd30: return "R3";
            6'd25, 6'd57, 6'd26, 6'd58, 6'd27, 6'd59,
            6'd28, 6'd60, 6'd29, 6'd61, 6'd31, 6'd63: return "R4";
            6'd2, 6'd34, 6'd44, 6'd55: return "R7";
            6'd35, 6'd49: return "R8";
            6'd1, 6'd33, 6'd6, 6'd38, 6'd8, 6'd40, 6'd9, 6'd41,
            6'd13, 6'd45, 6'd14, 6'd46, 6'd50: return "R2";
            default: return "R12";
        endcase
    endfunction

    task automatic judge(input string who, input string req, input logic v, input logic w,
                         input logic [4:0] i, input logic [31:0] dt, input logic [2:0] t,
                         input logic [40:0] e);
        bit bad;
        checks++;
        bad = (v !== 1'b1) || (w !== e[40]) || (t !== e[2:0]) ||
              (e[40] && ((i !== e[39:35]) || (dt !== e[34:3])));
        if (bad) begin
            fails++;
            $display("FAIL %s %s: got v=%0b wen=%0b idx=%0d data=%h trap=%0d expected wen=%0b idx=%0d data=%h trap=%0d",
                     req, who, v, w, i, dt, t, e[40], e[39:35], e[34:3], e[2:0]);
        end
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        logic [40:0] ef, el;
        string r;
        insn = ins; opnd_a = a; opnd_b = b; in_valid = 1'b1;
        ef = model(ins, a, b, 1'b1);
        el = model(ins, a, b, 1'b0);
        r  = req_of(ins);
        @(negedge clk);
        judge("full", r, f_vld, f_wen, f_idx, f_dat, f_trp, ef);
        judge("lite", r, l_vld, l_wen, l_idx, l_dat, l_trp, el);
        if (ef[40] && ef[39:35] == 5'd0) begin
            checks++; fails++;
            $display("FAIL R11 model wrote r0 got 1 expected 0");
        end
    endtask

    function automatic logic [31:0] rr(input logic [5:0] op, input logic [4:0] s0,
                                       input logic [4:0] s1, input logic [4:0] d);
        return {op, s0, s1, d, 11'd0};
    endfunction
    function automatic logic [31:0] ri(input logic [5:0] op, input logic [4:0] s0,
                                       input logic [4:0] d, input logic [15:0] im);
        return {op, s0, d, im};
    endfunction

    function automatic logic [31:0] pick_val();
        case ($urandom % 8)
            0: return 32'd0;
            1: return 32'd1;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] ins;
        void'($urandom(32'd7731));
        repeat (3) @(negedge clk);
        // R13 reset state
        checks++;
        if (f_vld !== 1'b0 || f_wen !== 1'b0 || f_trp !== 3'd0 || l_vld !== 1'b0) begin
            fails++;
            $display("FAIL R13 reset got v=%0b wen=%0b trap=%0d expected 0 0 0", f_vld, f_wen, f_trp);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // directed corner cases
        issue(rr(6'd45, 5'd1, 5'd2, 5'd3), 32'hFFFF_FFFF, 32'd2);          // R2 wrap add
        issue(ri(6'd13, 5'd1, 5'd4, 16'hFFFE), 32'd5, 32'd0);               // R2 sign-ext imm
        issue(ri(6'd14, 5'd1, 5'd4, 16'h8000), 32'd1, 32'd0);               // R2 zero-ext imm
        issue(rr(6'd50, 5'd1, 5'd2, 5'd6), 32'd3, 32'd5);                   // R2 sub
        issue(ri(6'd24, 5'd1, 5'd7, 16'h00F0), 32'hFFFF_FFFF, 32'd0);       // R3
        issue(ri(6'd30, 5'd0, 5'd7, 16'h1234), 32'd0, 32'd0);               // R3
        issue(ri(6'd26, 5'd1, 5'd8, 16'hFFFF), 32'd0, 32'd0);               // R4 0 > -1 signed
        issue(ri(6'd29, 5'd1, 5'd8, 16'hFFFF), 32'd0, 32'd0);               // R4 0 > 65535 unsigned
        issue(rr(6'd60, 5'd1, 5'd2, 5'd8), 32'h8000_0000, 32'd1);           // R4
        issue(rr(6'd37, 5'd1, 5'd2, 5'd9), 32'h8000_0010, 32'd33);          // R5 low 5 bits -> 1
        issue(ri(6'd5, 5'd1, 5'd9, 16'd4), 32'h8000_0000, 32'd0);           // R5/R6 lite trap
        issue(ri(6'd0, 5'd1, 5'd9, 16'd1), 32'h8000_0001, 32'd0);           // R6 lite legal
        issue(rr(6'd47, 5'd1, 5'd2, 5'd9), 32'd3, 32'd1);                   // R6 left traps lite
        issue(rr(6'd34, 5'd1, 5'd2, 5'd10), 32'h0001_0001, 32'h0001_0001);  // R7
        issue(rr(6'd44, 5'd1, 5'd0, 5'd10), 32'h0000_0080, 32'd0);          // R7
        issue(rr(6'd35, 5'd1, 5'd2, 5'd11), 32'd100, 32'd7);                // R8
        issue(rr(6'd49, 5'd1, 5'd2, 5'd11), 32'd100, 32'd7);                // R8
        issue(rr(6'd35, 5'd1, 5'd2, 5'd11), 32'd100, 32'd0);                // R8 zero divisor
        issue(rr(6'd40, 5'd0, 5'd0, 5'd0), 32'd0, 32'd0);                   // R9 halt
        issue(rr(6'd40, 5'd0, 5'd0, 5'd1), 32'd0, 32'd0);                   // R9 not halt
        issue(rr(6'd45, 5'd1, 5'd2, 5'd0), 32'd1, 32'd1);                   // R11 r0 dest
        issue(ri(6'd4, 5'd1, 5'd3, 16'd8), 32'd1, 32'd1);                   // R12 foreign
        issue(rr(6'd52, 5'd1, 5'd2, 5'd3), 32'd1, 32'd1);                   // R12 foreign

        // R1 idle cycle gives no output
        in_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (f_vld !== 1'b0 || f_wen !== 1'b0 || l_vld !== 1'b0) begin
            fails++;
            $display("FAIL R1 idle got v=%0b wen=%0b expected 0 0", f_vld, f_wen);
        end

        // constrained random mix (R1 field decode throughout)
        for (int n = 0; n < 4000; n++) begin
            ins = $urandom;
            case ($urandom % 6)
                0: ins[4:0] = 5'd1;
                1: ins[25:11] = 15'd0;
                default: ;
            endcase
            issue(ins, pick_val(), pick_val());
        end

        in_valid = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule